// File: doc/BRIEF.md
# Synchronous I2S Rate-Doubling Upsampler

The block takes a stereo I2S stream and always re-emits it as a stereo I2S stream at the top frame rate of its rate family. Every clock involved comes from one master clock, which runs at 64 times the output frame rate. The input may arrive at the output rate, at half of it or at a quarter of it. The input bit clock is presented as a one-cycle strobe in the master-clock domain, and it marks each rising input bit-clock edge.

The block counts master-clock cycles between rising edges of the input word-select line. From that count it classifies the input rate as upsampling factor 1, 2 or 4. It deserialises each complete 24-bit word per channel and latches a stereo pair once the right word has finished. The output serialiser takes a fresh snapshot of the latched pair at every output frame boundary. Upsampling therefore always replicates whole sample words and never repeated bits.

In repeat mode, each input pair fills as many output frames as the factor. In zero-stuff mode, the first output frame after a new pair carries that pair and the following frames carry zero. This suits a later interpolation filter. The output stays silent until the rate measurement has settled, and also whenever the input rate cannot be recognised.

Top module: `i2s_upsampler`

## Requirements
- R1: A frame period within ±2 master-clock cycles of 64, 128 or 256 is classed as factor code 0, 1 or 2 (×1, ×2, ×4) on `up_factor`. `rate_locked` rises after two consecutive measured periods fall in the same class, and it is low after reset.
- R2: A period outside all three windows, or no rising word-select edge for TIMEOUT cycles, sets `rate_invalid` and clears `rate_locked`. While locked, `rate_invalid` is low.
- R3: While not locked, every output frame carries all-zero data in both channels.
- R4: The output frame lasts 64 master-clock cycles. `out_lrclk` is low for 32 cycles (left) and high for 32 cycles (right). Each slot carries its 24-bit word MSB first, starting one cycle after the word-select change. The remaining 8 slot bits are zero.
- R5: The input uses the same format, with one bit taken per `in_bit_stb` pulse. A word belongs to the left channel when `in_lrclk` is low. A pair is formed only from a left word followed by a right word.
- R6: In repeat mode (`zero_stuff` low) each input pair appears, complete and unaltered, in exactly F consecutive output frames, with pairs in input order.
- R7: In zero-stuff mode each input pair appears in one output frame, followed by F−1 all-zero frames, with pairs in input order.
- R8: A change of input rate drops the lock, mutes the output, and relocks at the new factor. Output data changes only at frame boundaries.
- R9: While `rate_locked` stays high, `up_factor` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 64× output frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit_stb | input | 1 | One-cycle pulse per rising input bit-clock edge |
| in_lrclk | input | 1 | Input word select, low = left |
| in_data | input | 1 | Input serial data |
| zero_stuff | input | 1 | 1 = zero-stuff mode, 0 = repeat mode |
| out_lrclk | output | 1 | Output word select, low = left |
| out_data | output | 1 | Output serial data, one bit per master clock |
| rate_locked | output | 1 | Input rate recognised and stable |
| rate_invalid | output | 1 | Last period unrecognised or word select stopped |
| up_factor | output | 2 | Factor code: 0 = ×1, 1 = ×2, 2 = ×4 |

## Verification
The bench builds the block with its defaults: 32-bit slots, 24-bit samples, a ±2 cycle window and a 511-cycle timeout. Together these make every rate and mode combination short enough to sweep completely. Each input frame carries a distinct word that encodes its index, so the decoded output sequence reveals its order, run lengths and zero gaps regardless of the output frame phase. An unrecognised period of 100 cycles and a stalled word-select line bring the mute path and the timeout within reach. So does a return to a valid rate afterwards.

// File: rtl/upsr_pkg.sv
package upsr_pkg;

  typedef enum logic [1:0] {
    RATE_X1   = 2'd0,
    RATE_X2   = 2'd1,
    RATE_X4   = 2'd2,
    RATE_NONE = 2'd3
  } rate_e;

  function automatic logic in_window(input int unsigned period,
                                     input int unsigned nominal,
                                     input int unsigned tol);
    return (period + tol >= nominal) && (period <= nominal + tol);
  endfunction

  // base is the number of master-clock cycles in one output frame
  function automatic rate_e classify_period(input int unsigned period,
                                            input int unsigned base,
                                            input int unsigned tol);
    rate_e res;
    res = RATE_NONE;
    if (in_window(period, base, tol))          res = RATE_X1;
    else if (in_window(period, 2 * base, tol)) res = RATE_X2;
    else if (in_window(period, 4 * base, tol)) res = RATE_X4;
    return res;
  endfunction

endpackage

// File: rtl/upsr_rst_sync.sv
module upsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/upsr_rate_detect.sv
module upsr_rate_detect
  import upsr_pkg::*;
#(
  parameter int SLOT_W  = 32,
  parameter int TOL     = 2,
  parameter int TIMEOUT = 511
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lrclk,
  output logic  locked,
  output logic  invalid,
  output rate_e factor
);
  localparam int BASE  = 2 * SLOT_W;
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic             lr_q, lr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ref_q, ref_d;
  rate_e            prev_q, prev_d;
  logic             locked_q, locked_d;
  logic             invalid_q, invalid_d;
  rate_e            factor_q, factor_d;

  logic  rise;
  logic  expired;
  rate_e cls;

  always_comb begin
    rise      = lrclk & ~lr_q;
    expired   = (cnt_q == CNT_W'(TIMEOUT));
    cls       = classify_period(32'(cnt_q), BASE, TOL);
    lr_d      = lrclk;
    cnt_d     = expired ? cnt_q : cnt_q + CNT_W'(1);
    ref_d     = ref_q;
    prev_d    = prev_q;
    locked_d  = locked_q;
    invalid_d = invalid_q;
    factor_d  = factor_q;
    if (rise) begin
      cnt_d = CNT_W'(1);
      ref_d = 1'b1;
      if (ref_q) begin
        prev_d    = cls;
        invalid_d = (cls == RATE_NONE);
        if ((cls != RATE_NONE) && (cls == prev_q)) begin
          locked_d = 1'b1;
          factor_d = cls;
        end else begin
          locked_d = 1'b0;
        end
      end
    end else if (expired) begin
      ref_d     = 1'b0;
      prev_d    = RATE_NONE;
      locked_d  = 1'b0;
      invalid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q      <= 1'b0;
      cnt_q     <= '0;
      ref_q     <= 1'b0;
      prev_q    <= RATE_NONE;
      locked_q  <= 1'b0;
      invalid_q <= 1'b0;
      factor_q  <= RATE_X1;
    end else begin
      lr_q      <= lr_d;
      cnt_q     <= cnt_d;
      ref_q     <= ref_d;
      prev_q    <= prev_d;
      locked_q  <= locked_d;
      invalid_q <= invalid_d;
      factor_q  <= factor_d;
    end
  end

  assign locked  = locked_q;
  assign invalid = invalid_q;
  assign factor  = factor_q;

  // R1: lock is only ever gained on a measured word-select edge
  a_r1_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(rise));

  // R9: the reported factor holds while the lock holds
  a_r9_factor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) |-> $stable(factor_q));
endmodule

// File: rtl/upsr_deser.sv
module upsr_deser #(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                lrclk,
  input  logic                data,
  output logic                pair_load,
  output logic [SAMPLE_W-1:0] pair_l,
  output logic [SAMPLE_W-1:0] pair_r
);
  localparam int BC_W = $clog2(SLOT_W);

  logic                lrb_q, lrb_d;
  logic                align_q, align_d;
  logic [BC_W-1:0]     bcnt_q, bcnt_d;
  logic [SAMPLE_W-1:0] shr_q, shr_d;
  logic [SAMPLE_W-1:0] left_q, left_d;
  logic                lok_q, lok_d;
  logic [SAMPLE_W-1:0] pl_q, pl_d;
  logic [SAMPLE_W-1:0] pr_q, pr_d;
  logic                load_q, load_d;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    word    = {shr_q[SAMPLE_W-2:0], data};
    lrb_d   = lrb_q;
    align_d = align_q;
    bcnt_d  = bcnt_q;
    shr_d   = shr_q;
    left_d  = left_q;
    lok_d   = lok_q;
    pl_d    = pl_q;
    pr_d    = pr_q;
    load_d  = 1'b0;
    if (bit_stb) begin
      lrb_d = lrclk;
      if (lrclk != lrb_q) begin
        // this bit closes the previous slot; the MSB follows
        bcnt_d  = '0;
        align_d = 1'b1;
      end else if (align_q) begin
        if (bcnt_q < BC_W'(SAMPLE_W)) begin
          shr_d = word;
          if (bcnt_q == BC_W'(SAMPLE_W - 1)) begin
            if (!lrclk) begin
              left_d = word;
              lok_d  = 1'b1;
            end else if (lok_q) begin
              pl_d   = left_q;
              pr_d   = word;
              load_d = 1'b1;
              lok_d  = 1'b0;
            end
          end
        end
        if (bcnt_q != BC_W'(SLOT_W - 1)) bcnt_d = bcnt_q + BC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrb_q   <= 1'b0;
      align_q <= 1'b0;
      bcnt_q  <= '0;
      shr_q   <= '0;
      left_q  <= '0;
      lok_q   <= 1'b0;
      pl_q    <= '0;
      pr_q    <= '0;
      load_q  <= 1'b0;
    end else begin
      lrb_q   <= lrb_d;
      align_q <= align_d;
      bcnt_q  <= bcnt_d;
      shr_q   <= shr_d;
      left_q  <= left_d;
      lok_q   <= lok_d;
      pl_q    <= pl_d;
      pr_q    <= pr_d;
      load_q  <= load_d;
    end
  end

  assign pair_load = load_q;
  assign pair_l    = pl_q;
  assign pair_r    = pr_q;

  // R5: a stereo pair is released only after a left word was captured
  a_r5_pair_after_left: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> $past(lok_q));
endmodule

// File: rtl/upsr_ser.sv
module upsr_ser #(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mute,
  input  logic                zero_stuff,
  input  logic                pair_load,
  input  logic [SAMPLE_W-1:0] pair_l,
  input  logic [SAMPLE_W-1:0] pair_r,
  output logic                lrclk,
  output logic                data
);
  localparam int SLOT_B = $clog2(SLOT_W);
  localparam int OC_W   = SLOT_B + 1;
  localparam int IDX_W  = $clog2(SAMPLE_W);

  logic [OC_W-1:0]     oc_q, oc_d;
  logic [SAMPLE_W-1:0] sl_q, sl_d;
  logic [SAMPLE_W-1:0] sr_q, sr_d;
  logic                fresh_q, fresh_d;
  logic                fstart;

  always_comb begin
    fstart  = (oc_q == '0);
    oc_d    = oc_q + OC_W'(1);
    sl_d    = sl_q;
    sr_d    = sr_q;
    fresh_d = fresh_q;
    if (fstart) begin
      fresh_d = 1'b0;
      if (mute || (zero_stuff && !fresh_q)) begin
        sl_d = '0;
        sr_d = '0;
      end else begin
        sl_d = pair_l;
        sr_d = pair_r;
      end
    end
    if (pair_load) fresh_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q    <= '0;
      sl_q    <= '0;
      sr_q    <= '0;
      fresh_q <= 1'b0;
    end else begin
      oc_q    <= oc_d;
      sl_q    <= sl_d;
      sr_q    <= sr_d;
      fresh_q <= fresh_d;
    end
  end

  logic [SLOT_B-1:0]   pos;
  logic [SAMPLE_W-1:0] cur;
  int unsigned         idx;

  always_comb begin
    pos   = oc_q[SLOT_B-1:0];
    lrclk = oc_q[SLOT_B];
    cur   = oc_q[SLOT_B] ? sr_q : sl_q;
    idx   = SAMPLE_W - 32'(pos);
    data  = 1'b0;
    if ((pos != '0) && (32'(pos) <= SAMPLE_W)) data = cur[idx[IDX_W-1:0]];
  end

  // R8: snapshot words change only at an output frame boundary
  a_r8_whole_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q != '0) |=> ($stable(sl_q) && $stable(sr_q)));

  // R4: word select returns low (left) when a frame wraps
  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q == OC_W'(2 * SLOT_W - 1)) |=> !lrclk);
endmodule

// File: rtl/i2s_upsampler.sv
module i2s_upsampler
  import upsr_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int TOL      = 2,
  parameter int TIMEOUT  = 511
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_bit_stb,
  input  logic       in_lrclk,
  input  logic       in_data,
  input  logic       zero_stuff,
  output logic       out_lrclk,
  output logic       out_data,
  output logic       rate_locked,
  output logic       rate_invalid,
  output logic [1:0] up_factor
);
  logic                srst_n;
  logic                locked_w;
  logic                invalid_w;
  rate_e               factor_w;
  logic                load_w;
  logic [SAMPLE_W-1:0] pl_w;
  logic [SAMPLE_W-1:0] pr_w;

  upsr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  upsr_rate_detect #(
    .SLOT_W (SLOT_W),
    .TOL    (TOL),
    .TIMEOUT(TIMEOUT)
  ) u_rate (
    .clk    (clk),
    .rst_n  (srst_n),
    .lrclk  (in_lrclk),
    .locked (locked_w),
    .invalid(invalid_w),
    .factor (factor_w)
  );

  upsr_deser #(
    .SLOT_W  (SLOT_W),
    .SAMPLE_W(SAMPLE_W)
  ) u_deser (
    .clk      (clk),
    .rst_n    (srst_n),
    .bit_stb  (in_bit_stb),
    .lrclk    (in_lrclk),
    .data     (in_data),
    .pair_load(load_w),
    .pair_l   (pl_w),
    .pair_r   (pr_w)
  );

  upsr_ser #(
    .SLOT_W  (SLOT_W),
    .SAMPLE_W(SAMPLE_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (srst_n),
    .mute      (~locked_w),
    .zero_stuff(zero_stuff),
    .pair_load (load_w),
    .pair_l    (pl_w),
    .pair_r    (pr_w),
    .lrclk     (out_lrclk),
    .data      (out_data)
  );

  assign rate_locked  = locked_w;
  assign rate_invalid = invalid_w;
  assign up_factor    = factor_w;

  // R2: an unrecognised rate never coexists with a lock
  a_r2_invalid_unlocked: assert property (@(posedge clk) disable iff (!srst_n)
    rate_invalid |-> !rate_locked);
endmodule

// File: tb/i2s_upsampler_tb_top.sv
module i2s_upsampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF       = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_bit_stb = 1'b0;
  logic in_lrclk = 1'b0;
  logic in_data = 1'b0;
  logic zero_stuff = 1'b0;
  logic out_lrclk, out_data, rate_locked, rate_invalid;
  logic [1:0] up_factor;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2s_upsampler dut_i (
    .clk(clk), .rst_n(rst_n), .in_bit_stb(in_bit_stb), .in_lrclk(in_lrclk),
    .in_data(in_data), .zero_stuff(zero_stuff), .out_lrclk(out_lrclk),
    .out_data(out_data), .rate_locked(rate_locked), .rate_invalid(rate_invalid),
    .up_factor(up_factor)
  );

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] smp(input int i, input int ch);
    logic [9:0]  iv;
    logic [11:0] lo;
    iv = 10'(i);
    lo = 12'(i * 37 + ch * 5);
    return {1'b1, ch[0], iv, lo};
  endfunction

  // input driver: mode 0 = I2S at factor drv_f, 1 = bad period of 100, 2 = stalled
  int drv_mode = 0;
  int drv_f    = 1;
  int idx      = 0;

  initial begin
    wait (rst_n);
    forever begin
      if (drv_mode == 0) begin
        int f;
        f = drv_f;
        for (int b = 0; b < 64; b++) begin
          for (int j = 0; j < f; j++) begin
            logic [23:0] w;
            int sb;
            @(negedge clk);
            sb = b % 32;
            w  = smp(idx, (b >= 32) ? 1 : 0);
            in_bit_stb = (j == 0);
            in_lrclk   = (b >= 32);
            in_data    = (sb >= 1 && sb <= 24) ? w[24 - sb] : 1'b0;
          end
        end
        idx = (idx + 1) % 1024;
      end else if (drv_mode == 1) begin
        for (int k = 0; k < 100; k++) begin
          @(negedge clk);
          in_bit_stb = 1'b1;
          in_lrclk   = (k >= 50);
          in_data    = 1'b0;
        end
      end else begin
        for (int k = 0; k < 64; k++) begin
          @(negedge clk);
          in_bit_stb = 1'b0;
        end
      end
    end
  end

  // output decoder and monitors
  bit          dec_en = 0;
  bit          collect = 0;
  bit          dstart = 0;
  logic        dlr = 1'b0;
  int          dpos = 0;
  logic [23:0] dword = '0;
  logic [23:0] dleft = '0;
  int          fmt_err = 0;
  int          nfr = 0;
  logic [23:0] fl[MAXF];
  logic [23:0] fr[MAXF];
  bit          saw_unlock = 0;
  int          fac_chg = 0;
  logic [1:0]  fac_ref = '0;

  always @(negedge clk) begin
    if (dec_en) begin
      if (out_lrclk != dlr) begin
        if (dstart && dpos != 31) fmt_err++;
        dpos   = 0;
        dstart = 1;
      end else begin
        dpos++;
      end
      dlr = out_lrclk;
      if (dpos >= 1 && dpos <= 24) dword = {dword[22:0], out_data};
      else if (out_data) fmt_err++;
      if (dpos == 24) begin
        if (!out_lrclk) dleft = dword;
        else if (collect && nfr < MAXF) begin
          fl[nfr] = dleft;
          fr[nfr] = dword;
          nfr++;
        end
      end
      if (!rate_locked) saw_unlock = 1;
      if (collect && rate_locked && up_factor != fac_ref) fac_chg++;
    end
  end

  function automatic bit valid_frame(input int k);
    int i;
    i = int'(fl[k][21:12]);
    return (fl[k] == smp(i, 0)) && (fr[k] == smp(i, 1));
  endfunction

  task automatic analyze(input int f, input bit zs);
    int bad = 0, order = 0, lenerr = 0, seen = 0, prev = -1, run = 0, gap = 0;
    bit first_run = 1;
    for (int k = 0; k < nfr; k++) begin
      bit z;
      int i;
      z = (fl[k] == '0) && (fr[k] == '0);
      i = int'(fl[k][21:12]);
      if (zs) begin
        if (z) begin
          if (prev >= 0) gap++;
        end else begin
          if (!valid_frame(k)) bad++;
          if (prev >= 0) begin
            if (i != (prev + 1) % 1024) order++;
            if (gap != f - 1) lenerr++;
          end
          seen++;
          prev = i;
          gap  = 0;
        end
      end else begin
        if (!valid_frame(k)) bad++;
        if (prev < 0) begin
          prev = i; run = 1; seen = 1;
        end else if (i == prev) begin
          run++;
        end else begin
          if (i != (prev + 1) % 1024) order++;
          if (!first_run && run != f) lenerr++;
          first_run = 0;
          prev = i; run = 1; seen++;
        end
      end
    end
    if (zs) begin
      check(bad == 0, "R7 whole words in zero-stuff frames", bad, 0);
      check(order == 0, "R7 sample order", order, 0);
      check(lenerr == 0, "R7 zero gap length", lenerr, 0);
      check(seen >= 6, "R7 samples observed", seen, 6);
    end else begin
      check(bad == 0, "R6 whole words in repeated frames", bad, 0);
      check(order == 0, "R6 sample order", order, 0);
      check(lenerr == 0, "R6 repeat run length", lenerr, 0);
      check(seen >= 6, "R6 samples observed", seen, 6);
    end
    check(fmt_err == 0, "R4 slot length and unused bits", fmt_err, 0);
  endtask

  task automatic run_phase(input int f, input bit zs, input bit rate_change);
    int code;
    code = (f == 1) ? 0 : (f == 2) ? 1 : 2;
    @(posedge clk);
    saw_unlock = 0;
    drv_mode   = 0;
    drv_f      = f;
    zero_stuff = zs;
    repeat (8 * 64 * f + 300) @(posedge clk);
    @(negedge clk);
    check(rate_locked == 1'b1, "R1 locked", int'(rate_locked), 1);
    check(int'(up_factor) == code, "R1 factor code", int'(up_factor), code);
    check(rate_invalid == 1'b0, "R2 invalid low while locked", int'(rate_invalid), 0);
    if (rate_change) check(saw_unlock, "R8 lock dropped on rate change", int'(saw_unlock), 1);
    @(posedge clk);
    fac_ref = up_factor;
    fac_chg = 0;
    nfr     = 0;
    collect = 1;
    repeat (12 * 64 * f) @(posedge clk);
    collect = 0;
    @(negedge clk);
    check(fac_chg == 0, "R9 factor stable while locked", fac_chg, 0);
    analyze(f, zs);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rate_locked == 1'b0, "R1 reset: unlocked", int'(rate_locked), 0);
    check(rate_invalid == 1'b0, "R2 reset: invalid low", int'(rate_invalid), 0);
    check(out_lrclk == 1'b0 || out_lrclk == 1'b1, "R4 reset: word select known", 0, 0);
    check(out_data == 1'b0, "R3 reset: data muted", int'(out_data), 0);
    dec_en = 1;

    run_phase(1, 0, 0);
    run_phase(1, 1, 0);
    run_phase(2, 1, 1);
    run_phase(2, 0, 0);
    run_phase(4, 0, 1);
    run_phase(4, 1, 0);

    // unrecognised period: flagged and muted (R2, R3)
    @(posedge clk);
    drv_mode = 1;
    repeat (600) @(posedge clk);
    @(negedge clk);
    check(rate_invalid == 1'b1, "R2 bad period flagged", int'(rate_invalid), 1);
    check(rate_locked == 1'b0, "R2 bad period unlocks", int'(rate_locked), 0);
    @(posedge clk);
    nfr = 0;
    collect = 1;
    repeat (800) @(posedge clk);
    collect = 0;
    begin
      int nz = 0;
      for (int k = 0; k < nfr; k++) if (fl[k] != '0 || fr[k] != '0) nz++;
      check(nz == 0, "R3 muted frames all zero", nz, 0);
      check(nfr >= 10, "R3 muted frames observed", nfr, 10);
    end

    // stalled word select: timeout (R2)
    @(posedge clk);
    drv_mode = 2;
    repeat (900) @(posedge clk);
    @(negedge clk);
    check(rate_invalid == 1'b1, "R2 timeout flagged", int'(rate_invalid), 1);
    check(rate_locked == 1'b0, "R2 timeout unlocked", int'(rate_locked), 0);

    // recovery at a new rate (R8)
    run_phase(2, 0, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule